// File: doc/BRIEF.md
# Save Image Fill Classifier

This block watches the bytes read back from a cartridge's battery-backed save memory and labels the image once the readout ends. It reports three things. The first is whether every byte equals the first one, and if so which value that is. The second is whether such a solid fill is 0x00 or 0xFF, which points to a memory chip that was never enabled or to an unwired region. The third is how many different byte values appeared, counted up to a cap. A readout that shows only a few different values looks like an undriven bus, even when the bytes are not all equal. A readout that reaches the cap looks like real data.

A stream opens with a start pulse and closes with a last pulse. Bytes arrive as valid/ready beats. The block never applies back-pressure: `in_ready` is held high, so every beat with `in_valid` high is taken in that cycle. A beat is counted only while a stream is open, or in the same cycle as a start pulse. `in_last` may come with a byte, in which case the byte is counted and then the stream closes. It may also come alone with `in_valid` low, which closes the stream without adding a byte. The result pins are registered. `res_valid` marks the cycle in which they are final, and they hold their values until the next start.

Top module: `fill_classifier`

## Requirements
- R1: After reset, `in_ready` is 1, and `res_valid`, `res_uniform`, `res_suspect`, `res_diverse` and `res_distinct` are 0, `res_empty` is 1 and `res_fill` is 0x00.
- R2: When every counted byte of a stream equals its first byte, `res_uniform` is 1 and `res_fill` carries that byte. Otherwise `res_uniform` is 0 and `res_fill` is 0x00.
- R3: A stream that closes with no byte counted reports `res_empty` = 1, `res_uniform` = 0, `res_fill` = 0x00 and `res_distinct` = 0.
- R4: `res_suspect` is 1 exactly when `res_uniform` is 1 and the fill byte is 0x00 or 0xFF. A uniform fill of any other value leaves it 0.
- R5: `res_distinct` counts the different byte values in the stream. It stops at 16 and never goes above 16.
- R6: `res_diverse` is 1 when `res_distinct` has reached 16. A stream with fewer different values, including one that cycles through a few values, reports `res_diverse` = 0 and `res_uniform` = 0.
- R7: `res_valid` is high for exactly one cycle, the cycle after the beat that closes the stream is taken. The result pins keep their values until the next start.
- R8: A start pulse in the middle of a stream discards everything collected so far. A byte that arrives in the same cycle as the start counts as the first byte of the new stream.
- R9: Bytes that arrive while no stream is open (before the first start, or after a close and before the next start) change no output.
- R10: `in_ready` stays at 1. Bytes may be separated by idle cycles. A last pulse with `in_valid` low closes the stream without adding a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Always 1; the block accepts every beat |
| in_data | input | DATA_W (8) | Byte read from the save memory |
| in_start | input | 1 | Opens a new stream and clears collected state |
| in_last | input | 1 | Closes the stream (with or without a byte) |
| res_valid | output | 1 | One-cycle marker that the results are final |
| res_uniform | output | 1 | Every byte equals the first byte |
| res_fill | output | DATA_W (8) | Fill value when uniform, else 0 |
| res_empty | output | 1 | No byte counted in the stream |
| res_suspect | output | 1 | Uniform fill of 0x00 or 0xFF |
| res_distinct | output | 5 | Distinct byte values, capped at DIV_CAP (16) |
| res_diverse | output | 1 | The distinct count reached DIV_CAP |

## Verification
The hardest case to reach from the ports is the distinct counter at its cap. Reaching it needs exactly sixteen new values, followed by more new values that must not move it. It also needs a value to be repeated back-to-back in the cycle right after it was first seen, because that is where the occupancy update and the count update must agree. The stimulus therefore sends an ascending run well past sixteen values with repeated bytes placed inside it. A second stream reuses the same values after a mid-stream start, which shows that the start cleared the occupancy vector in one cycle.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  // Verdict flags gathered into one bundle at the top level.
  typedef struct packed {
    logic uniform;
    logic empty;
    logic suspect;
    logic diverse;
  } fcl_flags_t;
endpackage

// File: rtl/fcl_stream_ctl.sv
module fcl_stream_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_start,
  input  logic in_last,
  output logic take,
  output logic clear,
  output logic done_pulse
);
  logic open_q;
  logic live;

  // A start pulse makes the current cycle part of the new stream.
  assign live  = in_start | open_q;
  assign take  = in_valid & live;
  assign clear = in_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= in_last & live;
      if (in_start) open_q <= ~in_last;
      else if (in_last) open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fcl_occupancy.sv
module fcl_occupancy #(
  parameter int DATA_W  = 8,
  parameter int DIV_CAP = 16,
  localparam int NVAL   = 1 << DATA_W,
  localparam int CNT_W  = $clog2(DIV_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [DATA_W-1:0] data,
  output logic [CNT_W-1:0]  count
);
  logic [NVAL-1:0]  seen_q;
  logic             is_new;
  logic [CNT_W-1:0] base;

  // On a clearing cycle the vector is treated as empty before this byte.
  assign is_new = clear | ~seen_q[data];
  assign base   = clear ? '0 : count;

  for (genvar v = 0; v < NVAL; v++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) seen_q[v] <= 1'b0;
      else if (take && data == DATA_W'(v)) seen_q[v] <= 1'b1;
      else if (clear) seen_q[v] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (take && is_new && base < CNT_W'(DIV_CAP)) count <= base + 1'b1;
    else count <= base;
  end
endmodule

// File: rtl/fcl_uniform.sv
module fcl_uniform #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [DATA_W-1:0] data,
  output logic              have,
  output logic              same,
  output logic [DATA_W-1:0] first
);
  logic have_base;

  assign have_base = have & ~clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have  <= 1'b0;
      same  <= 1'b0;
      first <= '0;
    end else if (take && !have_base) begin
      have  <= 1'b1;
      same  <= 1'b1;
      first <= data;
    end else if (take) begin
      if (data != first) same <= 1'b0;
    end else if (clear) begin
      have  <= 1'b0;
      same  <= 1'b0;
      first <= '0;
    end
  end
endmodule

// File: rtl/fill_classifier.sv
module fill_classifier
  import fcl_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_CAP = 16,
  localparam int CNT_W  = $clog2(DIV_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_start,
  input  logic              in_last,
  output logic              res_valid,
  output logic              res_uniform,
  output logic [DATA_W-1:0] res_fill,
  output logic              res_empty,
  output logic              res_suspect,
  output logic [CNT_W-1:0]  res_distinct,
  output logic              res_diverse
);
  logic              take, clear;
  logic              have, same;
  logic [DATA_W-1:0] first;
  logic [CNT_W-1:0]  count;
  fcl_flags_t        flags;

  assign in_ready = 1'b1;

  fcl_stream_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .take(take), .clear(clear), .done_pulse(res_valid)
  );

  fcl_occupancy #(.DATA_W(DATA_W), .DIV_CAP(DIV_CAP)) u_occ (
    .clk(clk), .rst_n(rst_n), .clear(clear), .take(take), .data(in_data),
    .count(count)
  );

  fcl_uniform #(.DATA_W(DATA_W)) u_uni (
    .clk(clk), .rst_n(rst_n), .clear(clear), .take(take), .data(in_data),
    .have(have), .same(same), .first(first)
  );

  always_comb begin
    flags.uniform = have & same;
    flags.empty   = ~have;
    flags.suspect = flags.uniform & ((first == '0) | (first == '1));
    flags.diverse = (count >= CNT_W'(DIV_CAP));
  end

  assign res_uniform  = flags.uniform;
  assign res_empty    = flags.empty;
  assign res_suspect  = flags.suspect;
  assign res_diverse  = flags.diverse;
  assign res_fill     = flags.uniform ? first : '0;
  assign res_distinct = count;
endmodule

// File: rtl/fcl_checker.sv
module fcl_checker #(
  parameter int DATA_W  = 8,
  parameter int DIV_CAP = 16,
  localparam int CNT_W  = $clog2(DIV_CAP + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              in_last,
  input logic              res_valid,
  input logic              res_uniform,
  input logic [DATA_W-1:0] res_fill,
  input logic              res_empty,
  input logic              res_suspect,
  input logic [CNT_W-1:0]  res_distinct,
  input logic              res_diverse
);
  // R10
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
  // R7
  valid_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_last));
  // R2
  uniform_one_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_uniform |-> res_distinct == CNT_W'(1));
  // R3
  empty_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_empty |-> (!res_uniform && res_distinct == '0 && res_fill == '0));
  // R4
  suspect_needs_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_suspect |-> res_uniform);
  // R5
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_distinct <= CNT_W'(DIV_CAP));
  // R6
  diverse_not_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_diverse |-> !res_uniform);
endmodule

bind fill_classifier fcl_checker #(.DATA_W(DATA_W), .DIV_CAP(DIV_CAP)) u_fcl_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .in_last(in_last),
  .res_valid(res_valid), .res_uniform(res_uniform), .res_fill(res_fill),
  .res_empty(res_empty), .res_suspect(res_suspect),
  .res_distinct(res_distinct), .res_diverse(res_diverse)
);

// File: tb/test_fill_classifier.sv
module test_fill_classifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, res_valid, res_uniform, res_empty, res_suspect, res_diverse;
  logic [7:0] res_fill;
  logic [4:0] res_distinct;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Reference model state
  bit seen[256];
  int m_cnt;
  bit m_have, m_same, m_open, m_rv;
  int m_first;

  always #4 clk = ~clk;  // 125 MHz

  fill_classifier i_fill_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_start(in_start), .in_last(in_last),
    .res_valid(res_valid), .res_uniform(res_uniform), .res_fill(res_fill),
    .res_empty(res_empty), .res_suspect(res_suspect),
    .res_distinct(res_distinct), .res_diverse(res_diverse)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model, advanced on each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (seen[i]) seen[i] = 1'b0;
      m_cnt = 0; m_have = 0; m_same = 0; m_open = 0; m_rv = 0; m_first = 0;
    end else begin
      bit live;
      live = in_start || m_open;
      if (in_start) begin
        foreach (seen[i]) seen[i] = 1'b0;
        m_cnt = 0; m_have = 0; m_same = 0; m_first = 0;
      end
      if (in_valid && live) begin
        if (!seen[in_data]) begin
          seen[in_data] = 1'b1;
          if (m_cnt < 16) m_cnt++;
        end
        if (!m_have) begin
          m_have = 1; m_same = 1; m_first = in_data;
        end else if (in_data != m_first) m_same = 0;
      end
      m_rv = in_last && live;
      if (in_start) m_open = !in_last;
      else if (in_last) m_open = 0;
    end
  end

  // Per-clock comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit uni;
      uni = m_have && m_same;
      check("R10 ready", in_ready, 1);
      check("R7 res_valid", res_valid, m_rv);
      check("R2 res_uniform", res_uniform, uni);
      check("R2 res_fill", res_fill, uni ? m_first : 0);
      check("R3 res_empty", res_empty, !m_have);
      check("R4 res_suspect", res_suspect, uni && (m_first == 0 || m_first == 255));
      check("R5 res_distinct", res_distinct, m_cnt);
      check("R6 res_diverse", res_diverse, m_cnt >= 16);
    end
  end

  task automatic drive(bit v, int d, bit s, bit l);
    in_valid = v; in_data = 8'(d); in_start = s; in_last = l;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_start = 0; in_last = 0;
  endtask

  task automatic send(int vals[$]);
    foreach (vals[i]) drive(1, vals[i], i == 0, i == vals.size() - 1);
  endtask

  task automatic expect_result(string req, int uni, int fill, int sus, int cnt, int div);
    check({req, " valid pulse"}, res_valid, 1);
    check({req, " uniform"}, res_uniform, uni);
    check({req, " fill"}, res_fill, fill);
    check({req, " suspect"}, res_suspect, sus);
    check({req, " distinct"}, res_distinct, cnt);
    check({req, " diverse"}, res_diverse, div);
    drive(0, 0, 0, 0);
    check({req, " R7 pulse ends"}, res_valid, 0);
  endtask

  initial begin
    #80000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int q[$];
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", res_valid, 0);
    check("R1 empty", res_empty, 1);
    check("R1 distinct", res_distinct, 0);
    check("R1 ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: bytes before any start are ignored
    for (int i = 0; i < 5; i++) drive(1, 8'h10 + i, 0, i == 4);
    check("R9 before start distinct", res_distinct, 0);
    check("R9 before start valid", res_valid, 0);

    // R2: uniform non-suspect fill
    q = {}; for (int i = 0; i < 20; i++) q.push_back(8'hA5);
    send(q); expect_result("R2 A5", 1, 8'hA5, 0, 1, 0);

    // R9: bytes after close leave the result held (R7 hold)
    for (int i = 0; i < 4; i++) drive(1, i, 0, 0);
    check("R9 held uniform", res_uniform, 1);
    check("R9 held fill", res_fill, 8'hA5);
    check("R9 held distinct", res_distinct, 1);

    // R4: suspect fills
    q = {}; for (int i = 0; i < 10; i++) q.push_back(8'h00);
    send(q); expect_result("R4 zero", 1, 0, 1, 1, 0);
    q = {}; for (int i = 0; i < 12; i++) q.push_back(8'hFF);
    send(q); expect_result("R4 ones", 1, 8'hFF, 1, 1, 0);

    // R3: empty stream, start then lone last (R10), then start+last together
    drive(0, 0, 1, 0);
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 1);
    expect_result("R3 empty", 0, 0, 0, 0, 0);
    check("R3 empty flag", res_empty, 1);
    drive(0, 0, 1, 1);
    expect_result("R3 empty same cycle", 0, 0, 0, 0, 0);

    // R6: rotating four values is low diversity and not uniform
    q = {}; for (int i = 0; i < 32; i++) q.push_back(i % 4 == 0 ? 8'hEC : i % 4 == 1 ? 8'hCC : i % 4 == 2 ? 8'hFC : 8'hEE);
    send(q); expect_result("R6 rotate", 0, 0, 0, 4, 0);

    // R5/R6: ascending run with back-to-back repeats, well past the cap
    q = {};
    for (int i = 0; i < 40; i++) begin q.push_back(i * 3); if (i % 5 == 0) q.push_back(i * 3); end
    send(q); expect_result("R5 saturate", 0, 0, 0, 16, 1);

    // R8: mid-stream start discards the earlier bytes, start byte counts
    drive(1, 8'h01, 1, 0);
    for (int i = 0; i < 20; i++) drive(1, i * 3, 0, 0);
    drive(1, 8'h33, 1, 0);
    for (int i = 0; i < 5; i++) drive(1, 8'h33, 0, 0);
    drive(1, 8'h33, 0, 1);
    expect_result("R8 restart", 1, 8'h33, 0, 1, 0);

    // R10: idle gaps inside the stream, close with valid low
    drive(1, 8'h5A, 1, 0);
    drive(0, 8'h77, 0, 0);
    drive(1, 8'h5A, 0, 0);
    drive(0, 8'h99, 0, 0);
    drive(1, 8'h5B, 0, 0);
    drive(0, 8'h00, 0, 1);
    expect_result("R10 gaps", 0, 0, 0, 2, 0);

    // R7: single-byte stream, pulse for one cycle only
    drive(1, 8'h42, 1, 1);
    expect_result("R7 single", 1, 8'h42, 0, 1, 0);
    repeat (3) drive(0, 0, 0, 0);
    check("R7 no repeat pulse", res_valid, 0);
    check("R7 hold fill", res_fill, 8'h42);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule